// File: doc/BRIEF.md
# Whole-Message UART Transmitter

This block takes messages from upstream logic one byte per cycle and sends them on a serial line as 8N1 characters. Each message opens with a start marker that carries its declared length and closes with an end marker. Admission is decided on the opening byte. If the declared length fits in the free space of the byte queue, the whole message goes in. If it does not fit, the message is discarded, nothing already queued is disturbed, and a saturating drop counter steps once.

The line rate is one of five rates picked by a select code, and it changes only on an explicit apply command. The new code is sampled only while the serializer is idle, so a character already on the wire always finishes at the rate it started with. A guard period follows each change. During the guard no new message is admitted and no character starts, which leaves the far end time to retune.

Top module: `msg_uart_tx`

## Requirements
- R1: After reset `txd` is 1, `tx_busy` is 0, `guard_active` is 0 and `drop_count` is 0, and the reset rate is select code 0.
- R2: Each character is one start bit at 0, then eight data bits with the least significant bit first, then one stop bit at 1. With no character in flight `txd` stays at 1.
- R3: Every bit lasts round(CLK_HZ / rate) clock cycles. The rate is 57600 × 2^code for codes 0 to 4, and codes 5 to 7 give 921600.
- R4: A message is one cycle with `in_valid` and `in_sop` high, `in_len` giving the total byte count, followed by `in_valid` cycles with `in_sop` low. It is admitted when 1 ≤ `in_len` ≤ DEPTH minus the bytes held, and its bytes are then sent in arrival order.
- R5: A message whose `in_len` is 0 or larger than the free space is discarded as a whole and `drop_count` goes up by 1. Messages already queued are still sent unchanged.
- R6: `drop_count` holds at its all-ones value instead of wrapping. A cycle with `drop_clear` high sets it to 0 on the next edge and overrides a drop in the same cycle.
- R7: Input bytes past the declared length, bytes after an `in_eop`, and bytes of a discarded message are never queued or sent.
- R8: A `baud_apply` that arrives while a character is being sent is held back. The character ends at the old rate, and only then is `baud_sel` sampled and `guard_active` raised.
- R9: `guard_active` stays high for exactly GUARD_CYCLES cycles after the rate is applied. While it is high, a new start-of-message is ignored without counting a drop, and no character starts.
- R10: After the guard ends, queued and new characters are sent at the newly applied rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input byte present this cycle |
| in_sop | input | 1 | Byte opens a message; `in_len` is valid |
| in_eop | input | 1 | Byte closes a message |
| in_len | input | LEN_W | Declared message length in bytes (at start only) |
| in_data | input | 8 | Message byte |
| drop_clear | input | 1 | Clears the drop counter |
| baud_sel | input | 3 | Rate select code |
| baud_apply | input | 1 | Command to apply `baud_sel` |
| txd | output | 1 | Serial output, idle high |
| tx_busy | output | 1 | A character is on the wire |
| guard_active | output | 1 | Post-change guard period running |
| drop_count | output | CNT_W | Discarded message count, saturating |

## Verification
Single-byte messages are sent at every select code, including a code above the table, and the data values are chosen to separate the failure modes. Patterns with both polarities in bit 0 and bit 7 expose bit-order and framing errors. The byte 0x01 gives an isolated start bit whose length is counted exactly, which tells one divisor from another. A burst of three messages, where the middle one is too long for the queue, checks that the drop removes only that message and keeps the order of its neighbours. A message that overruns its declared length, and a stray byte with no opening marker, check that nothing leaks past the length rule. Rate changes are issued both at idle and in the middle of a character, which tells the deferred switch apart from an immediate one. A message offered during the guard shows that it is ignored and not counted.

// File: rtl/mtx_pkg.sv
`timescale 1ns/1ps
package mtx_pkg;
   localparam int NUM_RATES = 5;
   localparam int BASE_BAUD = 57600;
   localparam int SEL_W     = 3;

   // rate for a table index, indices past the end use the fastest rate
   function automatic int baud_of(input int idx);
      int k;
      k = (idx > NUM_RATES - 1) ? NUM_RATES - 1 : idx;
      return BASE_BAUD << k;
   endfunction

   // rounded clock cycles per bit
   function automatic int div_of(input int clk_hz, input int idx);
      int b;
      b = baud_of(idx);
      return (clk_hz + b / 2) / b;
   endfunction
endpackage

// File: rtl/mtx_fifo.sv
`timescale 1ns/1ps
module mtx_fifo #(
   parameter int DEPTH = 16,
   parameter int OCC_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [7:0]       wr_data,
   input  logic             rd_en,
   output logic [7:0]       rd_data,
   output logic [OCC_W-1:0] occ
);
   localparam int PTR_W = $clog2(DEPTH);

   logic [7:0]       mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr;
   logic [PTR_W-1:0] rd_ptr;

   assign rd_data = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_ptr] <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         occ    <= '0;
      end else begin
         if (wr_en) wr_ptr <= wr_ptr + 1'b1;
         if (rd_en) rd_ptr <= rd_ptr + 1'b1;
         case ({wr_en, rd_en})
            2'b10:   occ <= occ + 1'b1;
            2'b01:   occ <= occ - 1'b1;
            default: occ <= occ;
         endcase
      end
   end
endmodule

// File: rtl/mtx_admit.sv
`timescale 1ns/1ps
module mtx_admit #(
   parameter int DEPTH = 16,
   parameter int OCC_W = 5,
   parameter int LEN_W = 8,
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic             in_sop,
   input  logic             in_eop,
   input  logic [LEN_W-1:0] in_len,
   input  logic [7:0]       in_data,
   input  logic [OCC_W-1:0] occ,
   input  logic             guard,
   input  logic             drop_clear,
   output logic             wr_en,
   output logic [7:0]       wr_data,
   output logic [CNT_W-1:0] drop_count
);
   localparam logic [CNT_W-1:0] CNT_TOP = '1;

   logic [LEN_W-1:0] remaining;
   logic             opening;
   logic             fits;
   logic             cont_ok;
   logic             drop_ev;

   assign opening = in_valid & in_sop & ~guard;
   assign fits    = (in_len != '0) && (int'(in_len) <= DEPTH - int'(occ));
   assign cont_ok = in_valid & ~in_sop & (remaining != '0);
   assign drop_ev = opening & ~fits;
   assign wr_en   = (opening & fits) | cont_ok;
   assign wr_data = in_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         remaining <= '0;
      end else if (in_valid & in_eop & (opening | ~in_sop)) begin
         remaining <= '0;
      end else if (opening) begin
         remaining <= fits ? in_len - 1'b1 : '0;
      end else if (cont_ok) begin
         remaining <= remaining - 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         drop_count <= '0;
      end else if (drop_clear) begin
         drop_count <= '0;
      end else if (drop_ev && drop_count != CNT_TOP) begin
         drop_count <= drop_count + 1'b1;
      end
   end
endmodule

// File: rtl/mtx_rate_ctl.sv
`timescale 1ns/1ps
module mtx_rate_ctl
   import mtx_pkg::*;
#(
   parameter int CLK_HZ       = 250_000_000,
   parameter int GUARD_CYCLES = 25_000_000,
   parameter int INIT_SEL     = 0,
   parameter int DIV_W        = 13,
   parameter int GUARD_W      = 25
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SEL_W-1:0] baud_sel,
   input  logic             baud_apply,
   input  logic             ser_idle,
   output logic [DIV_W-1:0] div,
   output logic             guard_active,
   output logic             hold
);
   logic [DIV_W-1:0]   div_tab [NUM_RATES];
   logic [SEL_W-1:0]   cur_idx;
   logic [SEL_W-1:0]   req_idx;
   logic [GUARD_W-1:0] guard_cnt;
   logic               pending;
   logic               apply_now;

   for (genvar g = 0; g < NUM_RATES; g++) begin : g_rate
      assign div_tab[g] = DIV_W'(div_of(CLK_HZ, g));
   end

   assign req_idx      = (int'(baud_sel) >= NUM_RATES) ? SEL_W'(NUM_RATES - 1) : baud_sel;
   assign div          = div_tab[cur_idx];
   assign apply_now    = (baud_apply | pending) & ser_idle;
   assign guard_active = (guard_cnt != '0);
   assign hold         = pending | baud_apply | guard_active;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_idx   <= SEL_W'(INIT_SEL);
         guard_cnt <= '0;
         pending   <= 1'b0;
      end else if (apply_now) begin
         cur_idx   <= req_idx;
         guard_cnt <= GUARD_W'(GUARD_CYCLES);
         pending   <= 1'b0;
      end else begin
         if (baud_apply)   pending   <= 1'b1;
         if (guard_active) guard_cnt <= guard_cnt - 1'b1;
      end
   end
endmodule

// File: rtl/mtx_serial.sv
`timescale 1ns/1ps
module mtx_serial #(
   parameter int DIV_W = 13
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div,
   input  logic             start_ok,
   input  logic [7:0]       data,
   output logic             pop,
   output logic             busy,
   output logic             txd
);
   localparam int FRAME_BITS = 10;
   localparam int IDX_W      = $clog2(FRAME_BITS);

   logic [FRAME_BITS-1:0] sh;
   logic [IDX_W-1:0]      bit_idx;
   logic [DIV_W-1:0]      tick;

   assign pop = ~busy & start_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh      <= '1;
         bit_idx <= '0;
         tick    <= '0;
         busy    <= 1'b0;
         txd     <= 1'b1;
      end else if (pop) begin
         sh      <= {1'b1, data, 1'b0};
         bit_idx <= '0;
         tick    <= div - 1'b1;
         busy    <= 1'b1;
         txd     <= 1'b0;
      end else if (busy) begin
         if (tick == '0) begin
            if (int'(bit_idx) == FRAME_BITS - 1) begin
               busy <= 1'b0;
               txd  <= 1'b1;
            end else begin
               bit_idx <= bit_idx + 1'b1;
               sh      <= {1'b1, sh[FRAME_BITS-1:1]};
               txd     <= sh[1];
               tick    <= div - 1'b1;
            end
         end else begin
            tick <= tick - 1'b1;
         end
      end
   end
endmodule

// File: rtl/msg_uart_tx.sv
`timescale 1ns/1ps
module msg_uart_tx
   import mtx_pkg::*;
#(
   parameter int CLK_HZ       = 250_000_000,
   parameter int GUARD_CYCLES = CLK_HZ / 10,
   parameter int INIT_SEL     = 0,
   parameter int DEPTH        = 16,
   parameter int LEN_W        = 8,
   parameter int CNT_W        = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic             in_sop,
   input  logic             in_eop,
   input  logic [LEN_W-1:0] in_len,
   input  logic [7:0]       in_data,
   input  logic             drop_clear,
   input  logic [2:0]       baud_sel,
   input  logic             baud_apply,
   output logic             txd,
   output logic             tx_busy,
   output logic             guard_active,
   output logic [CNT_W-1:0] drop_count
);
   localparam int OCC_W   = $clog2(DEPTH + 1);
   localparam int DIV_W   = $clog2(div_of(CLK_HZ, 0) + 1);
   localparam int GUARD_W = $clog2(GUARD_CYCLES + 1);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two, at least 2");
   end
   if (div_of(CLK_HZ, NUM_RATES - 1) < 2) begin : g_bad_clk
      $error("CLK_HZ too low for the fastest rate");
   end
   if (GUARD_CYCLES < 1) begin : g_bad_guard
      $error("GUARD_CYCLES must be at least 1");
   end
   if (LEN_W < OCC_W) begin : g_bad_len
      $error("LEN_W cannot express DEPTH");
   end
   if (INIT_SEL < 0 || INIT_SEL >= NUM_RATES) begin : g_bad_init
      $error("INIT_SEL out of range");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("CNT_W must be positive");
   end

   logic             wr_en;
   logic [7:0]       wr_data;
   logic             pop;
   logic [7:0]       head;
   logic [OCC_W-1:0] occ_w;
   logic [DIV_W-1:0] div_w;
   logic             hold;

   mtx_admit #(
      .DEPTH(DEPTH), .OCC_W(OCC_W), .LEN_W(LEN_W), .CNT_W(CNT_W)
   ) u_admit (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop),
      .in_len(in_len), .in_data(in_data),
      .occ(occ_w), .guard(guard_active), .drop_clear(drop_clear),
      .wr_en(wr_en), .wr_data(wr_data), .drop_count(drop_count)
   );

   mtx_fifo #(
      .DEPTH(DEPTH), .OCC_W(OCC_W)
   ) u_fifo (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_data(wr_data),
      .rd_en(pop), .rd_data(head), .occ(occ_w)
   );

   mtx_rate_ctl #(
      .CLK_HZ(CLK_HZ), .GUARD_CYCLES(GUARD_CYCLES), .INIT_SEL(INIT_SEL),
      .DIV_W(DIV_W), .GUARD_W(GUARD_W)
   ) u_rate (
      .clk(clk), .rst_n(rst_n),
      .baud_sel(baud_sel), .baud_apply(baud_apply), .ser_idle(~tx_busy),
      .div(div_w), .guard_active(guard_active), .hold(hold)
   );

   mtx_serial #(
      .DIV_W(DIV_W)
   ) u_ser (
      .clk(clk), .rst_n(rst_n),
      .div(div_w), .start_ok((occ_w != '0) & ~hold), .data(head),
      .pop(pop), .busy(tx_busy), .txd(txd)
   );
endmodule

// File: rtl/mtx_checker.sv
`timescale 1ns/1ps
module mtx_checker #(
   parameter int CNT_W = 16,
   parameter int DEPTH = 16,
   parameter int OCC_W = 5,
   parameter int DIV_W = 13
) (
   input logic             clk,
   input logic             rst_n,
   input logic             txd,
   input logic             tx_busy,
   input logic             guard_active,
   input logic             drop_clear,
   input logic [CNT_W-1:0] drop_count,
   input logic [OCC_W-1:0] occ,
   input logic [DIV_W-1:0] div
);
   localparam logic [CNT_W-1:0] CNT_TOP = '1;

   a_r2_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_busy |-> txd);

   a_r2_stop_high: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tx_busy) |-> txd);

   a_r5_step_one: assert property (@(posedge clk) disable iff (!rst_n)
      !drop_clear |=> (drop_count == $past(drop_count) ||
                       drop_count == $past(drop_count) + 1'b1));

   a_r6_saturate: assert property (@(posedge clk) disable iff (!rst_n)
      (drop_count == CNT_TOP && !drop_clear) |=> drop_count == CNT_TOP);

   a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
      drop_clear |=> drop_count == '0);

   a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      int'(occ) <= DEPTH);

   a_r8_rate_steady: assert property (@(posedge clk) disable iff (!rst_n)
      tx_busy |=> (!tx_busy || $stable(div)));

   a_r9_no_start_in_guard: assert property (@(posedge clk) disable iff (!rst_n)
      guard_active |=> !$rose(tx_busy));
endmodule

bind msg_uart_tx mtx_checker #(
   .CNT_W(CNT_W), .DEPTH(DEPTH), .OCC_W(OCC_W), .DIV_W(DIV_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .txd(txd), .tx_busy(tx_busy),
   .guard_active(guard_active), .drop_clear(drop_clear),
   .drop_count(drop_count), .occ(occ_w), .div(div_w)
);

// File: tb/sim_msg_uart_tx.sv
`timescale 1ns/1ps
module sim_msg_uart_tx;
   localparam int CLK_HZ = 9_216_000;
   localparam int GUARD  = 50;
   localparam int DEPTH  = 16;
   localparam int LEN_W  = 8;
   localparam int CNT_W  = 3;

   // {select code, data byte}
   localparam logic [10:0] VEC [6] = '{
      {3'd0, 8'hA5}, {3'd1, 8'h3C}, {3'd2, 8'h96},
      {3'd3, 8'hFF}, {3'd4, 8'h00}, {3'd7, 8'h5A}
   };

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
   logic [LEN_W-1:0] in_len = '0;
   logic [7:0]       in_data = '0;
   logic             drop_clear = 1'b0;
   logic [2:0]       baud_sel = '0;
   logic             baud_apply = 1'b0;
   logic             txd, tx_busy, guard_active;
   logic [CNT_W-1:0] drop_count;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   msg_uart_tx #(
      .CLK_HZ(CLK_HZ), .GUARD_CYCLES(GUARD), .INIT_SEL(0),
      .DEPTH(DEPTH), .LEN_W(LEN_W), .CNT_W(CNT_W)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
      .in_eop(in_eop), .in_len(in_len), .in_data(in_data),
      .drop_clear(drop_clear), .baud_sel(baud_sel), .baud_apply(baud_apply),
      .txd(txd), .tx_busy(tx_busy), .guard_active(guard_active),
      .drop_count(drop_count)
   );

   function automatic int exp_div(input int sel);
      int k;
      k = (sel > 4) ? 4 : sel;
      return CLK_HZ / (57600 << k);
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send_bytes(input int n, input int dlen, input logic [7:0] base);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 1'b1;
         in_sop   = (i == 0);
         in_eop   = (i == n - 1);
         in_len   = LEN_W'(dlen);
         in_data  = base + 8'(i);
      end
      @(negedge clk);
      in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
   endtask

   task automatic wait_low(output bit seen);
      int w;
      w = 0;
      while (txd !== 1'b0 && w < 5000) begin
         @(negedge clk);
         w++;
      end
      seen = (txd === 1'b0);
   endtask

   task automatic rx_byte(input int div, output logic [7:0] b, output bit ok);
      bit seen;
      b  = '0;
      ok = 1'b1;
      wait_low(seen);
      if (!seen) begin
         ok = 1'b0;
         return;
      end
      tick(div / 2);
      if (txd !== 1'b0) ok = 1'b0;
      for (int i = 0; i < 8; i++) begin
         tick(div);
         b[i] = txd;
      end
      tick(div);
      if (txd !== 1'b1) ok = 1'b0;
   endtask

   task automatic wait_idle();
      while (tx_busy) @(negedge clk);
   endtask

   task automatic set_rate(input int sel);
      wait_idle();
      @(negedge clk);
      baud_sel = 3'(sel); baud_apply = 1'b1;
      @(negedge clk);
      baud_apply = 1'b0;
      while (guard_active) @(negedge clk);
   endtask

   task automatic quiet(input int n, input string req);
      int lows;
      lows = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (txd !== 1'b1) lows++;
      end
      chk(req, lows, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [7:0] got;
      bit         ok;
      bit         seen;
      int         n;
      logic [7:0] rx [16];

      tick(3);
      chk("R1 txd in reset", int'(txd), 1);
      rst_n = 1'b1;
      tick(2);
      chk("R1 busy after reset", int'(tx_busy), 0);
      chk("R1 guard after reset", int'(guard_active), 0);
      chk("R1 drops after reset", int'(drop_count), 0);

      // R1: reset rate is code 0, no apply issued yet
      fork
         send_bytes(1, 1, 8'hC6);
         rx_byte(exp_div(0), got, ok);
      join
      chk("R1 reset rate data", int'(got), 8'hC6);
      chk("R2 reset rate frame", int'(ok), 1);

      // R2 R3 R10: table walk over select codes
      foreach (VEC[v]) begin
         set_rate(int'(VEC[v][10:8]));
         fork
            send_bytes(1, 1, VEC[v][7:0]);
            rx_byte(exp_div(int'(VEC[v][10:8])), got, ok);
         join
         chk("R3 R10 data at rate", int'(got), int'(VEC[v][7:0]));
         chk("R2 framing", int'(ok), 1);
      end

      // R3: exact start-bit length for two codes, one past the table
      for (int s = 2; s <= 6; s += 4) begin
         set_rate(s);
         send_bytes(1, 1, 8'h01);
         wait_low(seen);
         n = 0;
         while (txd === 1'b0) begin
            n++;
            @(negedge clk);
         end
         chk("R3 bit length", n, exp_div(s));
         wait_idle();
      end

      // R4 R5: burst with an oversize middle message
      set_rate(4);
      fork
         begin
            send_bytes(10, 10, 8'h10);
            send_bytes(1, 8, 8'hEE);
            send_bytes(6, 6, 8'h30);
         end
         for (int i = 0; i < 16; i++) rx_byte(exp_div(4), rx[i], ok);
      join
      for (int i = 0; i < 16; i++)
         chk("R4 R5 burst order", int'(rx[i]), (i < 10) ? 8'h10 + i : 8'h30 + i - 10);
      chk("R5 one drop counted", int'(drop_count), 1);
      quiet(200, "R5 dropped bytes not sent");

      // R5: zero length is a drop
      send_bytes(1, 0, 8'h44);
      tick(2);
      chk("R5 zero length drop", int'(drop_count), 2);
      quiet(200, "R5 zero length not sent");

      // R7: bytes past the declared length and stray bytes
      fork
         send_bytes(4, 2, 8'h50);
         begin
            rx_byte(exp_div(4), got, ok);
            chk("R7 first byte", int'(got), 8'h50);
            rx_byte(exp_div(4), got, ok);
            chk("R7 second byte", int'(got), 8'h51);
         end
      join
      @(negedge clk);
      in_valid = 1'b1; in_data = 8'h77;
      @(negedge clk);
      in_valid = 1'b0;
      quiet(300, "R7 overrun and stray bytes not sent");

      // R6: saturation and clear priority
      for (int i = 0; i < 7; i++) send_bytes(1, 200, 8'h01);
      tick(1);
      chk("R6 saturated", int'(drop_count), 7);
      @(negedge clk);
      drop_clear = 1'b1; in_valid = 1'b1; in_sop = 1'b1; in_len = 8'd200;
      @(negedge clk);
      drop_clear = 1'b0; in_valid = 1'b0; in_sop = 1'b0;
      chk("R6 clear beats drop", int'(drop_count), 0);

      // R9: guard duration
      wait_idle();
      @(negedge clk);
      baud_sel = 3'd4; baud_apply = 1'b1;
      @(negedge clk);
      baud_apply = 1'b0;
      n = 0;
      while (guard_active === 1'b1) begin
         n++;
         @(negedge clk);
      end
      chk("R9 guard length", n, GUARD);

      // R9: message offered in guard is ignored and not counted
      @(negedge clk);
      baud_apply = 1'b1;
      @(negedge clk);
      baud_apply = 1'b0;
      chk("R9 guard raised", int'(guard_active), 1);
      send_bytes(1, 1, 8'h99);
      while (guard_active) @(negedge clk);
      quiet(300, "R9 message in guard not sent");
      chk("R9 no drop in guard", int'(drop_count), 0);

      // R8: apply mid-character is deferred
      set_rate(3);
      fork
         begin
            send_bytes(1, 1, 8'hC3);
            tick(40);
            @(negedge clk);
            baud_sel = 3'd2; baud_apply = 1'b1;
            @(negedge clk);
            baud_apply = 1'b0;
            chk("R8 no guard mid-character", int'(guard_active), 0);
            chk("R8 still busy", int'(tx_busy), 1);
         end
         rx_byte(exp_div(3), got, ok);
      join
      chk("R8 old-rate byte", int'(got), 8'hC3);
      chk("R8 old-rate frame", int'(ok), 1);
      n = 0;
      while (!guard_active && n < 200) begin
         n++;
         @(negedge clk);
      end
      chk("R8 guard after stop bit", int'(guard_active), 1);
      while (guard_active) @(negedge clk);
      fork
         send_bytes(1, 1, 8'h5A);
         rx_byte(exp_div(2), got, ok);
      join
      chk("R10 new-rate byte", int'(got), 8'h5A);
      chk("R10 new-rate frame", int'(ok), 1);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule